// File: doc/BRIEF.md
# DMA Interrupt Status Controller

This block holds the one interrupt control and status word shared by a seven-channel DMA engine. Each channel reports a finished transfer with a one-cycle done pulse. The block latches that pulse as a per-channel flag, but only if software has enabled interrupts for that channel. It then combines the flags with the per-channel enables, a global enable and a force bit into a single master flag. The master flag drives a level interrupt request and a one-cycle rising-edge pulse.

Software sees one 32-bit word.

| Bits | Access | Meaning |
|------|--------|---------|
| [5:0] | read/write | general-purpose bits |
| [14:6] | read-only | always read as zero |
| 15 | read/write | force-interrupt bit |
| [22:16] | read/write | channel enable; channel n uses bit 16+n |
| 23 | read/write | global enable |
| [30:24] | write-one-to-clear | channel flag; channel n uses bit 24+n |
| 31 | read-only | master flag |

The register port has no handshake. A write is taken on every clock edge where the write strobe is high. The read data is always valid and shows the current register contents. No stream interface exists, so there is no back-pressure.

Top module: `dma_irq_status`

## Requirements
- R1: While reset is low, and in the first cycle after it, the read data is 0x00000000 and both irq and irq_rise are low.
- R2: A write loads only the bits in mask 0x00FF803F, which are bits [5:0], bit 15, bits [22:16] and bit 23. Bits [14:6] always read as zero.
- R3: A done pulse on channel n sets flag bit 24+n at the next edge, but only if enable bit 16+n was set before that edge. If the enable bit was clear, the pulse has no effect.
- R4: A write with a 1 in bit 24+n clears flag n. A write with a 0 in that bit leaves flag n unchanged.
- R5: If a done pulse for channel n (with its enable set) arrives in the same cycle as a write clearing flag n, the flag ends up set.
- R6: Bit 31 reads 1 when the force bit 15 is set. It also reads 1 when bit 23 is set and, for some channel n, both bit 16+n and bit 24+n are set. In all other cases it reads 0. Writes to bit 31 have no effect.
- R7: irq is equal to read-data bit 31 in every cycle.
- R8: irq_rise is high for exactly the one cycle in which bit 31 is 1 after having been 0 in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| chan_done | input | 7 | Per-channel transfer-done pulses |
| rd_data | output | 32 | Register readback |
| irq | output | 1 | Level interrupt request |
| irq_rise | output | 1 | One-cycle pulse on the rising edge of the master flag |

## Verification
The hardest case to reach is a write that clears a flag in the same cycle as a done pulse for that channel. This is the set-wins case in R5. The same case is harder still when that write also changes the channel's enable, because the pulse must use the enable value from before the write.

A directed step covers this collision explicitly. The random phase then drives writes and done pulses on the same cycles with high probability. It also biases write data so that enable bits are often set and flag-clear bits are often set. This repeatedly pushes the master flag through rises and falls while the force bit is clear.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int NCH        = 7;
  localparam int DW         = 32;
  localparam int GP_W       = 6;
  localparam int FORCE_BIT  = 15;
  localparam int EN_LSB     = 16;
  localparam int GEN_BIT    = EN_LSB + NCH;
  localparam int FLG_LSB    = 24;
  localparam int MASTER_BIT = FLG_LSB + NCH;
  localparam logic [DW-1:0] WR_MASK = 32'h00FF803F;

  typedef struct packed {
    logic [GP_W-1:0] gp;
    logic            force_irq;
    logic [NCH-1:0]  ch_en;
    logic            glob_en;
  } ctrl_t;
endpackage

// File: rtl/dma_irq_ctrl_field.sv
module dma_irq_ctrl_field
  import dma_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output ctrl_t         ctrl
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q.gp        <= wr_data[GP_W-1:0];
      ctrl_q.force_irq <= wr_data[FORCE_BIT];
      ctrl_q.ch_en     <= wr_data[EN_LSB +: NCH];
      ctrl_q.glob_en   <= wr_data[GEN_BIT];
    end
  end

  assign ctrl = ctrl_q;

  logic unused_wbits;
  assign unused_wbits = ^{wr_data[FORCE_BIT-1:GP_W], wr_data[DW-1:GEN_BIT+1]};
endmodule

// File: rtl/dma_irq_flag_bank.sv
module dma_irq_flag_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] done,
  input  logic [N-1:0] en,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  for (genvar g = 0; g < N; g++) begin : g_cell
    logic f_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        f_q <= 1'b0;
      end else if (done[g] && en[g]) begin
        f_q <= 1'b1;
      end else if (clr[g]) begin
        f_q <= 1'b0;
      end
    end
    assign flags[g] = f_q;
  end
endmodule

// File: rtl/dma_irq_master.sv
module dma_irq_master #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         force_irq,
  input  logic         glob_en,
  input  logic [N-1:0] en,
  input  logic [N-1:0] flags,
  output logic         master,
  output logic         rise
);
  logic master_q;

  assign master = force_irq | (glob_en & (|(en & flags)));

  always_ff @(posedge clk) begin
    if (!rst_n) master_q <= 1'b0;
    else        master_q <= master;
  end

  assign rise = master & ~master_q;
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
  import dma_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [NCH-1:0] chan_done,
  output logic [DW-1:0] rd_data,
  output logic          irq,
  output logic          irq_rise
);
  ctrl_t          ctrl;
  logic [NCH-1:0] flags;
  logic [NCH-1:0] clr;
  logic           master;

  dma_irq_ctrl_field u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .ctrl(ctrl)
  );

  assign clr = wr_en ? wr_data[FLG_LSB +: NCH] : '0;

  dma_irq_flag_bank #(.N(NCH)) u_flags (
    .clk(clk), .rst_n(rst_n), .done(chan_done), .en(ctrl.ch_en),
    .clr(clr), .flags(flags)
  );

  dma_irq_master #(.N(NCH)) u_master (
    .clk(clk), .rst_n(rst_n), .force_irq(ctrl.force_irq), .glob_en(ctrl.glob_en),
    .en(ctrl.ch_en), .flags(flags), .master(master), .rise(irq_rise)
  );

  always_comb begin
    rd_data = '0;
    rd_data[GP_W-1:0]       = ctrl.gp;
    rd_data[FORCE_BIT]      = ctrl.force_irq;
    rd_data[EN_LSB +: NCH]  = ctrl.ch_en;
    rd_data[GEN_BIT]        = ctrl.glob_en;
    rd_data[FLG_LSB +: NCH] = flags;
    rd_data[MASTER_BIT]     = master;
  end

  assign irq = master;
endmodule

// File: rtl/dma_irq_status_chk.sv
module dma_irq_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [6:0]  chan_done,
  input logic [31:0] rd_data,
  input logic        irq,
  input logic        irq_rise
);
  AST_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rd_data[14:6] == 9'h0); // R2
  AST_WRITE_MASK: assert property (@(posedge clk) disable iff (!rst_n) $past(wr_en) |-> ((rd_data & 32'h00FF803F) == ($past(wr_data) & 32'h00FF803F))); // R2
  AST_FLAG_SET_GATED: assert property (@(posedge clk) disable iff (!rst_n) (rd_data[30:24] & ~$past(rd_data[30:24]) & ~($past(chan_done) & $past(rd_data[22:16]))) == 7'h0); // R3
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ($past(rd_data[30:24]) & ~($past(wr_en) ? $past(wr_data[30:24]) : 7'h0) & ~rd_data[30:24]) == 7'h0); // R4
  AST_FORCE_IRQ: assert property (@(posedge clk) disable iff (!rst_n) rd_data[15] |-> irq); // R6
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) irq == rd_data[31]); // R7
  AST_RISE_EDGE: assert property (@(posedge clk) disable iff (!rst_n) irq_rise |-> (irq && !$past(irq))); // R8
endmodule

bind dma_irq_status dma_irq_status_chk u_chk (.*);

// File: tb/test_dma_irq_status.sv
`timescale 1ns/1ps
module test_dma_irq_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [6:0]  chan_done = '0;
  logic [31:0] rd_data;
  logic        irq, irq_rise;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_ctrl = '0;
  logic [6:0]  m_flags = '0;
  logic        m_prev = 1'b0;

  always #5 clk = ~clk;

  dma_irq_status i_dma_irq_status (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .chan_done(chan_done), .rd_data(rd_data), .irq(irq), .irq_rise(irq_rise)
  );

  function automatic logic master_of(logic [31:0] c, logic [6:0] f);
    return c[15] | (c[23] & (|(c[22:16] & f)));
  endfunction

  function automatic logic [31:0] word_of(logic [31:0] c, logic [6:0] f);
    return {master_of(c, f), f, c[23:0]};
  endfunction

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [31:0] w;
    logic m;
    w = word_of(m_ctrl, m_flags);
    m = w[31];
    check32({tag, " rd_data"}, rd_data, w);
    check32("R7 irq", {31'h0, irq}, {31'h0, m});
    check32("R8 irq_rise", {31'h0, irq_rise}, {31'h0, m & ~m_prev});
    m_prev = m;
  endtask

  task automatic step(input logic w, input logic [31:0] d, input logic [6:0] dn, input string tag);
    @(negedge clk);
    wr_en = w; wr_data = d; chan_done = dn;
    m_flags = (m_flags & ~(w ? d[30:24] : 7'h0)) | (dn & m_ctrl[22:16]);
    if (w) m_ctrl = d & 32'h00FF803F;
    @(posedge clk); #1;
    check_all(tag);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(posedge clk);
    #1;
    check32("R1 rd_data in reset", rd_data, 32'h0);
    check32("R1 irq in reset", {30'h0, irq, irq_rise}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check_all("R1 after reset");

    step(1'b1, 32'hFFFFFFFF, 7'h0, "R2 all-ones write");
    step(1'b1, 32'h0, 7'h0, "R2 zero write");
    step(1'b0, 32'h0, 7'h7F, "R3 done with enables off");
    step(1'b1, 32'h00850000, 7'h0, "R6 enable ch0 ch2 global");
    step(1'b0, 32'h0, 7'h05, "R3 done ch0 ch2");
    step(1'b0, 32'h0, 7'h02, "R3 done ch1 disabled");
    step(1'b1, 32'h00850000 | 32'h01000000, 7'h0, "R4 clear ch0 only");
    step(1'b1, 32'h00850000 | 32'h04000000, 7'h04, "R5 clear and set ch2");
    step(1'b1, 32'h80010000, 7'h0, "R6 global off bit31 ignored");
    step(1'b1, 32'h00008000, 7'h0, "R6 force only");
    step(1'b1, 32'h7F000000, 7'h0, "R4 clear all");
    step(1'b1, 32'h00FF0000, 7'h7F, "R3 enable write same cycle");

    for (int i = 0; i < 3000; i++) begin
      logic w;
      logic [31:0] d;
      logic [6:0] dn;
      w  = ($urandom % 3) != 0;
      d  = $urandom;
      d[15] = ($urandom % 8) == 0;
      d[23] = ($urandom % 4) != 0;
      dn = $urandom;
      step(w, d, dn, "R6 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule